// File: doc/BRIEF.md
# Three-Channel Down-Counting Interval Timer

This peripheral holds three independent down-counters behind one 32-bit register port. Every channel has its own control word, a stored interval and a live count value. A channel counts only while enabled. Its count rate comes from one of four tick-enable inputs, chosen per channel and then divided by a power-of-two prescaler. When the count reaches zero the channel raises a pending flag. In continuous mode it then refills from its interval. In single-shot mode it parks at zero and drops its own enable.

The three pending flags share one status word, and software clears them by writing ones. A shared enable word masks them onto the per-channel interrupt outputs. A reload request in the control word copies the interval into the counter on the channel's next tick, and the request then clears itself. Software uses this to start a channel from a known value. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads 0, no channel counts and every `irq` bit is 0.
- R2: Address 0x00 is the interrupt-enable word and 0x04 the pending word, where bit n belongs to channel n. Channel n has its control word at 0x10+0x10*n, its interval at 0x14+0x10*n and its read-only count at 0x18+0x10*n. The control and interval words read back what was written.
- R3: Control bit 1 is the reload request. On the channel's next tick the counter takes the interval value and the request bit reads 0.
- R4: Control bit 0 enables the channel. While it is set, each channel tick lowers a count above 1 by one. While it is clear, the count holds.
- R5: Control bit 7 clear selects continuous mode. A tick that finds the count at 1 or 0 sets the channel's pending bit and reloads the interval.
- R6: Control bit 7 set selects single-shot mode. A tick that finds the count at 1 or 0 sets the pending bit, leaves the count at 0 and clears control bit 0, so the channel stops.
- R7: Control bits 6:4 hold k. The channel ticks once per 2^k selected source ticks (k = 0 to 7).
- R8: Control bits 3:2 select which `src_tick` bit drives the channel. Pulses on the other source inputs have no effect on the count.
- R9: Writing 1 to a bit of the pending word clears that flag. Writing 0 leaves it unchanged.
- R10: `irq[n]` is high exactly when pending bit n and enable bit n are both 1.
- R11: If a channel expires in the same cycle that software writes 1 to its pending bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_tick | input | 4 | One tick-enable per clock source |
| irq | output | 3 | Per-channel interrupt |

## Verification
The case that matters is a channel expiring in the same clock cycle as a software write that clears its pending bit. The bench first brings channel 0 down to a count of 1. It then issues, in one cycle, a selected source tick together with a write of 1 to the pending word. The pending word must still read 1 and the count must already hold the reloaded interval. A later lone clear must then empty the bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW      = 32;
  localparam int SRC_W   = 2;
  localparam int NSRC    = 1 << SRC_W;
  localparam int PRE_W   = 3;
  localparam int CTRL_W  = 8;

  localparam logic [7:0] ADDR_IER = 8'h00;
  localparam logic [7:0] ADDR_ISR = 8'h04;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_INTV = 4'h4;
  localparam logic [3:0] OFF_CUR  = 4'h8;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] presc;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_in,
  input  logic [PW-1:0] k,
  output logic          tick_out
);
  localparam int CW = (1 << PW) - 1;

  logic [CW-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask     = ~({CW{1'b1}} << k);
    tick_out = run && tick_in && (cnt_q >= mask);
    cnt_d    = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (tick_in)
      cnt_d = (cnt_q >= mask) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_intv,
  input  logic [DW-1:0]     wdata,
  input  logic [NSRC-1:0]   src_tick,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  intv_o,
  output logic [CNT_W-1:0]  cur_o,
  output logic              expire_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] intv_q, intv_d, cur_q, cur_d;
  logic             src_sel, tick, expire;

  assign src_sel = src_tick[ctrl_q.src];

  tmr_prescale #(.PW(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.en),
    .tick_in (src_sel),
    .k       (ctrl_q.presc),
    .tick_out(tick)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    intv_d = intv_q;
    cur_d  = cur_q;
    expire = 1'b0;
    if (tick) begin
      if (ctrl_q.reload) begin
        cur_d         = intv_q;
        ctrl_d.reload = 1'b0;
      end else if (cur_q <= CNT_W'(1)) begin
        expire = 1'b1;
        if (ctrl_q.oneshot) begin
          cur_d     = '0;
          ctrl_d.en = 1'b0;
        end else begin
          cur_d = intv_q;
        end
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr_intv) intv_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cur_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      intv_q <= intv_d;
      cur_q  <= cur_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign intv_o   = intv_q;
  assign cur_o    = cur_q;
  assign expire_o = expire;

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl_q.reload && !wr_ctrl) |=> (cur_q == $past(intv_q) && !ctrl_q.reload));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_q.reload && cur_q > CNT_W'(1)) |=> (cur_q == $past(cur_q) - 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_q));

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.oneshot && !wr_ctrl) |=> (!ctrl_q.en && cur_q == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CNT_W = 32,
  parameter int AW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic [NCH-1:0]  irq
);
  localparam int SEL_W = AW - 4;

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [NCH-1:0]   ier_q, ier_d, pend_q, pend_d, exp_v;
  logic             wr_ier, wr_isr;
  ctrl_t            ch_ctrl [NCH];
  logic [CNT_W-1:0] ch_intv [NCH];
  logic [CNT_W-1:0] ch_cur  [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign wr_ier = bus_wr && (bus_addr == AW'(ADDR_IER));
  assign wr_isr = bus_wr && (bus_addr == AW'(ADDR_ISR));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = (bus_addr[AW-1:4] == SEL_W'(n + 1));
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_ctrl (bus_wr && hit && bus_addr[3:0] == OFF_CTRL),
      .wr_intv (bus_wr && hit && bus_addr[3:0] == OFF_INTV),
      .wdata   (bus_wdata),
      .src_tick(src_tick),
      .ctrl_o  (ch_ctrl[n]),
      .intv_o  (ch_intv[n]),
      .cur_o   (ch_cur[n]),
      .expire_o(exp_v[n])
    );
  end

  always_comb begin
    ier_d  = ier_q;
    pend_d = pend_q;
    if (wr_ier) ier_d  = bus_wdata[NCH-1:0];
    if (wr_isr) pend_d = pend_q & ~bus_wdata[NCH-1:0];
    pend_d = pend_d | exp_v;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ier_q  <= '0;
      pend_q <= '0;
    end else begin
      ier_q  <= ier_d;
      pend_q <= pend_d;
    end
  end

  assign irq = pend_q & ier_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_IER)) bus_rdata = DW'(ier_q);
    if (bus_addr == AW'(ADDR_ISR)) bus_rdata = DW'(pend_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr[AW-1:4] == SEL_W'(i + 1)) begin
        case (bus_addr[3:0])
          OFF_CTRL: bus_rdata = {{(DW-CTRL_W){1'b0}}, ch_ctrl[i]};
          OFF_INTV: bus_rdata = DW'(ch_intv[i]);
          OFF_CUR:  bus_rdata = DW'(ch_cur[i]);
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assert_expiry_sets_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|exp_v) |=> ((pend_q & $past(exp_v)) == $past(exp_v)));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_isr && exp_v == '0) |=> (pend_q == ($past(pend_q) & ~$past(bus_wdata[NCH-1:0]))));

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(irq & ~ier_q)) == 1'b0);
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick;
  logic [2:0]  irq;
  int checks = 0;
  int errors = 0;

  tmr_bank u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic tick(input logic [3:0] m, input int n);
    @(negedge clk);
    src_tick = m;
    repeat (n) @(negedge clk);
    src_tick = 4'h0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ier", 8'h00, 0);
    rd_chk("R1 isr", 8'h04, 0);
    for (int c = 0; c < 3; c++) begin
      rd_chk("R1 ctrl", 8'(8'h10 + 16*c), 0);
      rd_chk("R1 cur",  8'(8'h18 + 16*c), 0);
    end
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map;
    wr(8'h24, 32'hDEADBEEF);
    rd_chk("R2 intv1 readback", 8'h24, 32'hDEADBEEF);
    wr(8'h30, 32'h000000FC);
    rd_chk("R2 ctrl2 readback", 8'h30, 32'h000000FC);
    wr(8'h30, 0);
    tick(4'hF, 3);
    rd_chk("R4 disabled channel holds", 8'h38, 0);
  endtask

  task automatic t_continuous;
    wr(8'h14, 5);
    wr(8'h10, 32'h07);
    tick(4'h2, 1);
    rd_chk("R3 load", 8'h18, 5);
    rd_chk("R3 reload self-clear", 8'h10, 32'h05);
    tick(4'h2, 3);
    rd_chk("R4 decrement", 8'h18, 2);
    tick(4'h2, 1);
    rd_chk("R4 at one", 8'h18, 1);
    rd_chk("R5 not yet pending", 8'h04, 0);
    tick(4'h2, 1);
    rd_chk("R5 reload on expiry", 8'h18, 5);
    rd_chk("R5 pending set", 8'h04, 1);
    chk("R10 masked irq", 32'(irq), 0);
    wr(8'h00, 1);
    chk("R10 irq raised", 32'(irq), 1);
    wr(8'h04, 0);
    rd_chk("R9 write zero keeps", 8'h04, 1);
    wr(8'h04, 1);
    rd_chk("R9 write one clears", 8'h04, 0);
    chk("R10 irq dropped", 32'(irq), 0);
  endtask

  task automatic t_collision;
    tick(4'h2, 4);
    rd_chk("R11 setup count", 8'h18, 1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 1; src_tick = 4'h2;
    @(negedge clk);
    bus_wr = 1'b0; src_tick = 4'h0;
    rd_chk("R11 set wins over clear", 8'h04, 1);
    rd_chk("R11 reloaded", 8'h18, 5);
    wr(8'h04, 1);
    rd_chk("R11 later clear", 8'h04, 0);
    wr(8'h10, 0);
    tick(4'h2, 3);
    rd_chk("R4 hold when disabled", 8'h18, 5);
  endtask

  task automatic t_oneshot;
    wr(8'h24, 3);
    wr(8'h20, 32'h87);
    tick(4'h2, 1);
    rd_chk("R3 oneshot load", 8'h28, 3);
    tick(4'h2, 2);
    rd_chk("R4 oneshot count", 8'h28, 1);
    tick(4'h2, 1);
    rd_chk("R6 parked at zero", 8'h28, 0);
    rd_chk("R6 enable cleared", 8'h20, 32'h84);
    rd_chk("R6 pending", 8'h04, 32'h2);
    tick(4'h2, 3);
    rd_chk("R6 stays stopped", 8'h28, 0);
    chk("R10 ch1 masked", 32'(irq), 0);
  endtask

  task automatic t_prescale;
    wr(8'h34, 2);
    wr(8'h30, 32'h27);
    tick(4'h2, 4);
    rd_chk("R7 load after four", 8'h38, 2);
    tick(4'h2, 3);
    rd_chk("R7 no tick before four", 8'h38, 2);
    tick(4'h2, 1);
    rd_chk("R7 tick on fourth", 8'h38, 1);
    tick(4'h5, 8);
    rd_chk("R8 other sources ignored", 8'h38, 1);
    tick(4'h2, 4);
    rd_chk("R7 expiry reload", 8'h38, 2);
    rd_chk("R5 two pending", 8'h04, 32'h6);
    wr(8'h04, 32'h2);
    rd_chk("R9 selective clear", 8'h04, 32'h4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 0; src_tick = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_continuous();
    t_collision();
    t_oneshot();
    t_prescale();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule